// File: doc/BRIEF.md
# Gated Retired-Instruction Counter CSR

This block keeps a 64-bit count of retired instructions and serves read-only user-level views of that count, split into a low and a high 32-bit half. Each cycle the pipeline reports how many instructions retired (0, 1 or 2) and the count advances by that amount. Machine-level software can load either half through a write port. A write takes precedence over the increment in the cycle it happens.

A read request carries a CSR address, the current privilege mode, a virtualization flag, and the counter-enable bits granted by the machine, supervisor and hypervisor levels. The block answers in the same cycle with exactly one outcome: read data, an illegal-instruction fault or a virtual-instruction fault. Requests are always accepted, so there is no back-pressure. An outcome is only meaningful in a cycle where `req_valid` is high. Trap delivery and CSR instruction decode are left to the surrounding pipeline.

Top module: `retire_ctr_csr`

## Requirements
- R1: After reset the count is zero, so reads of both halves return 0.
- R2: Each cycle without a write, the count grows by `retire_cnt` (0 to 2) and wraps modulo 2^64.
- R3: A write with `wr_addr`=0xB02 loads bits 31:0 and a write with 0xB82 loads bits 63:32. The other half keeps its value, and no increment applies in that cycle. Writes to any other address leave the count unchanged.
- R4: A permitted read of 0xC02 or 0xB02 returns bits 31:0 and a permitted read of 0xC82 or 0xB82 returns bits 63:32.
- R5: Mode encoding is `req_mode` 3=M, 1=S, 0=U and 2=reserved. In M mode, reads of 0xC02 and 0xC82 never fault. Reads of 0xB02 and 0xB82 succeed only in M mode and raise an illegal fault in any other mode.
- R6: S mode (`req_virt`=0) reading 0xC02 or 0xC82 raises an illegal fault when `en_m` is 0 and succeeds otherwise.
- R7: U mode (`req_virt`=0) reading a user view needs both `en_m` and `en_s` when `s_present` is 1, and only `en_m` when `s_present` is 0. If the needed bits are not set, the read raises an illegal fault.
- R8: In VS mode (mode 1 with `req_virt`=1), a user-view read raises an illegal fault if `en_m`=0. Otherwise it raises a virtual fault if `en_h`=0, and succeeds if neither applies.
- R9: In VU mode (mode 0 with `req_virt`=1), a user-view read raises an illegal fault if `en_m`=0. Otherwise it raises a virtual fault unless both `en_h` and `en_s` are 1, and succeeds when all three bits are 1.
- R10: Any other address, and the reserved mode 2, raise an illegal fault. `req_virt` has no effect in M mode.
- R11: At most one fault output is high. Whenever a fault is raised, `rd_data` is 0. With `req_valid` low, all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_cnt | input | 2 | Instructions retired this cycle |
| s_present | input | 1 | Supervisor mode is implemented |
| en_m | input | 1 | Machine-level counter enable bit |
| en_s | input | 1 | Supervisor-level counter enable bit |
| en_h | input | 1 | Hypervisor-level counter enable bit |
| req_valid | input | 1 | Read request present |
| req_addr | input | 12 | CSR address of the read |
| req_mode | input | 2 | Privilege mode of the requester |
| req_virt | input | 1 | Requester runs virtualized |
| wr_en | input | 1 | Machine-level write strobe |
| wr_addr | input | 12 | CSR address of the write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, 0 on a fault |
| fault_illegal | output | 1 | Illegal-instruction fault |
| fault_virtual | output | 1 | Virtual-instruction fault |

## Verification
The permission logic is swept over every combination of mode, virtualization flag, the three enable bits, supervisor presence and the address. This exhaustive sweep separates the S, U, VS and VU rules, and it separates an illegal fault from a virtual fault when only the ordering of checks decides the outcome. The counter is driven with steady retire counts of 0, 1 and 2. It is also written near the all-ones value so that a carry has to cross from the low half into the high half, and then wrap the full 64 bits. A write is paired with a nonzero retire count to show that the write wins and that the other half is untouched.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam int unsigned CSR_AW = 12;
  localparam logic [CSR_AW-1:0] ADDR_USER_LO = 12'hC02;
  localparam logic [CSR_AW-1:0] ADDR_USER_HI = 12'hC82;
  localparam logic [CSR_AW-1:0] ADDR_MACH_LO = 12'hB02;
  localparam logic [CSR_AW-1:0] ADDR_MACH_HI = 12'hB82;

  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    VERDICT_OK   = 2'd0,
    VERDICT_ILL  = 2'd1,
    VERDICT_VIRT = 2'd2
  } verdict_e;

  typedef struct packed {
    logic hit;       // address names a counter view
    logic upper;     // selects bits of the high half
    logic user_view; // read-only user-level alias
  } csr_sel_t;
endpackage

// File: rtl/rc_counter.sv
module rc_counter #(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned HALF_W = 32,
  parameter int unsigned RET_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RET_W-1:0] retire,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [HALF_W-1:0] wr_data,
  output logic [CNT_W-1:0] count
);
  localparam int unsigned UP_W = CNT_W - HALF_W;

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;

  always_comb begin
    count_d = count_q + CNT_W'(retire);
    if (wr_lo) count_d = {count_q[CNT_W-1:HALF_W], wr_data};
    else if (wr_hi) count_d = {wr_data[UP_W-1:0], count_q[HALF_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign count = count_q;

  // R2: plain step adds the retire count
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_lo && !wr_hi) |=> count == $past(count) + CNT_W'($past(retire)));
  // R3: low write loads low half, high half held
  a_r3_wr_lo: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (count[HALF_W-1:0] == $past(wr_data))
              && (count[CNT_W-1:HALF_W] == $past(count[CNT_W-1:HALF_W])));
  // R3: high write loads high half, low half held
  a_r3_wr_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wr_lo) |=> (count[CNT_W-1:HALF_W] == $past(wr_data[UP_W-1:0]))
              && (count[HALF_W-1:0] == $past(count[HALF_W-1:0])));
endmodule

// File: rtl/rc_addr_decode.sv
module rc_addr_decode
  import rc_pkg::*;
(
  input  logic [CSR_AW-1:0] addr,
  output csr_sel_t          sel
);
  always_comb begin
    sel = '0;
    unique case (addr)
      ADDR_USER_LO: sel = '{hit: 1'b1, upper: 1'b0, user_view: 1'b1};
      ADDR_USER_HI: sel = '{hit: 1'b1, upper: 1'b1, user_view: 1'b1};
      ADDR_MACH_LO: sel = '{hit: 1'b1, upper: 1'b0, user_view: 1'b0};
      ADDR_MACH_HI: sel = '{hit: 1'b1, upper: 1'b1, user_view: 1'b0};
      default:      sel = '0;
    endcase
  end
endmodule

// File: rtl/rc_access_gate.sv
module rc_access_gate
  import rc_pkg::*;
(
  input  csr_sel_t   sel,
  input  logic [1:0] mode,
  input  logic       virt,
  input  logic       s_present,
  input  logic       en_m,
  input  logic       en_s,
  input  logic       en_h,
  output verdict_e   verdict
);
  always_comb begin
    verdict = VERDICT_ILL;
    if (!sel.hit) begin
      verdict = VERDICT_ILL;
    end else if (!sel.user_view) begin
      verdict = (mode == PRIV_M) ? VERDICT_OK : VERDICT_ILL;
    end else begin
      unique case (mode)
        PRIV_M: verdict = VERDICT_OK;
        PRIV_S: begin
          if (!en_m)              verdict = VERDICT_ILL;
          else if (virt && !en_h) verdict = VERDICT_VIRT;
          else                    verdict = VERDICT_OK;
        end
        PRIV_U: begin
          if (!en_m)                         verdict = VERDICT_ILL;
          else if (virt)                     verdict = (en_h && en_s) ? VERDICT_OK : VERDICT_VIRT;
          else if (s_present && !en_s)       verdict = VERDICT_ILL;
          else                               verdict = VERDICT_OK;
        end
        default: verdict = VERDICT_ILL;
      endcase
    end
  end
endmodule

// File: rtl/retire_ctr_csr.sv
module retire_ctr_csr
  import rc_pkg::*;
#(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned XLEN   = 32,
  parameter int unsigned RET_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RET_W-1:0]  retire_cnt,
  input  logic              s_present,
  input  logic              en_m,
  input  logic              en_s,
  input  logic              en_h,
  input  logic              req_valid,
  input  logic [CSR_AW-1:0] req_addr,
  input  logic [1:0]        req_mode,
  input  logic              req_virt,
  input  logic              wr_en,
  input  logic [CSR_AW-1:0] wr_addr,
  input  logic [XLEN-1:0]   wr_data,
  output logic [XLEN-1:0]   rd_data,
  output logic              fault_illegal,
  output logic              fault_virtual
);
  localparam int unsigned N_HALF = CNT_W / XLEN;

  logic [CNT_W-1:0] count;
  logic             wr_lo, wr_hi;
  csr_sel_t         sel;
  verdict_e         verdict;
  logic [XLEN-1:0]  half [N_HALF];

  assign wr_lo = wr_en && (wr_addr == ADDR_MACH_LO);
  assign wr_hi = wr_en && (wr_addr == ADDR_MACH_HI);

  rc_counter #(.CNT_W(CNT_W), .HALF_W(XLEN), .RET_W(RET_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .retire(retire_cnt),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data), .count(count)
  );

  rc_addr_decode u_dec (.addr(req_addr), .sel(sel));

  rc_access_gate u_gate (
    .sel(sel), .mode(req_mode), .virt(req_virt), .s_present(s_present),
    .en_m(en_m), .en_s(en_s), .en_h(en_h), .verdict(verdict)
  );

  for (genvar g = 0; g < N_HALF; g++) begin : g_half
    assign half[g] = count[g*XLEN +: XLEN];
  end

  always_comb begin
    rd_data       = '0;
    fault_illegal = 1'b0;
    fault_virtual = 1'b0;
    if (req_valid) begin
      fault_illegal = (verdict == VERDICT_ILL);
      fault_virtual = (verdict == VERDICT_VIRT);
      if (verdict == VERDICT_OK) rd_data = sel.upper ? half[N_HALF-1] : half[0];
    end
  end

  // R11: faults one-hot
  a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fault_illegal, fault_virtual}));
  // R11: faulting read returns zero
  a_r11_zero_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_illegal || fault_virtual) |-> rd_data == '0);
  // R11: idle request drives nothing
  a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!fault_illegal && !fault_virtual && rd_data == '0));
  // R5: machine mode never faults on user views
  a_r5_m_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == 2'd3
     && (req_addr == 12'hC02 || req_addr == 12'hC82))
    |-> (!fault_illegal && !fault_virtual));
  // R9: VU with every enable set succeeds
  a_r9_vu_open: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == 2'd0 && req_virt && en_m && en_s && en_h
     && req_addr == 12'hC82) |-> (!fault_illegal && !fault_virtual));
  // R1: count is zero just after reset
  a_r1_reset: assert property (@(posedge clk)
    !rst_n |=> count == '0);
endmodule

// File: tb/tb_retire_ctr_csr.sv
module tb_retire_ctr_csr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  retire_cnt = '0;
  logic        s_present = 1'b1, en_m = 1'b0, en_s = 1'b0, en_h = 1'b0;
  logic        req_valid = 1'b0, req_virt = 1'b0;
  logic [11:0] req_addr = '0, wr_addr = '0;
  logic [1:0]  req_mode = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        fault_illegal, fault_virtual;

  int checks = 0, errors = 0;
  logic [63:0] exp_cnt = '0;

  always #10 clk = ~clk;

  retire_ctr_csr dut (.*);

  // reference count from R1..R3
  always @(posedge clk) begin
    if (!rst_n) exp_cnt <= '0;
    else if (wr_en && wr_addr == 12'hB02) exp_cnt <= {exp_cnt[63:32], wr_data};
    else if (wr_en && wr_addr == 12'hB82) exp_cnt <= {wr_data, exp_cnt[31:0]};
    else exp_cnt <= exp_cnt + 64'(retire_cnt);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // expected {illegal, virtual} per R5..R10
  function automatic logic [1:0] want(input logic [1:0] m, input logic v, input logic sp,
                                      input logic bm, input logic bs, input logic bh,
                                      input logic [11:0] a);
    if (a == 12'hB02 || a == 12'hB82) return (m == 2'd3) ? 2'b00 : 2'b10;
    if (a != 12'hC02 && a != 12'hC82) return 2'b10;
    case (m)
      2'd3: return 2'b00;
      2'd1: if (!v) return bm ? 2'b00 : 2'b10;
            else return !bm ? 2'b10 : (!bh ? 2'b01 : 2'b00);
      2'd0: if (!v) return (bm && (bs || !sp)) ? 2'b00 : 2'b10;
            else return !bm ? 2'b10 : ((bh && bs) ? 2'b00 : 2'b01);
      default: return 2'b10;
    endcase
  endfunction

  task automatic rd(input logic [11:0] a, input logic [1:0] m, input logic v,
                    output logic [31:0] d, output logic [1:0] f);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_mode = m; req_virt = v;
    #1;
    d = rd_data; f = {fault_illegal, fault_virtual};
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [1:0] ret);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; retire_cnt = ret;
    @(negedge clk);
    wr_en = 1'b0; retire_cnt = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d; logic [1:0] f;
    rd(12'hC02, 2'd3, 1'b0, d, f); chk("R1 low after reset", d, 32'h0);
    rd(12'hC82, 2'd3, 1'b0, d, f); chk("R1 high after reset", d, 32'h0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    req_valid = 1'b0; req_addr = 12'h123; req_mode = 2'd0;
    #1;
    chk("R11 idle outputs", {rd_data[29:0], fault_illegal, fault_virtual}, 32'h0);
  endtask

  task automatic t_increment;
    logic [31:0] d; logic [1:0] f;
    for (int r = 0; r < 3; r++) begin
      @(negedge clk); retire_cnt = 2'(r);
      repeat (5) @(negedge clk);
      retire_cnt = '0;
      rd(12'hC02, 2'd3, 1'b0, d, f);
      chk("R2 step count", d, exp_cnt[31:0]);
    end
    chk("R2 total after 0/1/2 runs", exp_cnt[31:0], 32'd15);
  endtask

  task automatic t_write_and_carry;
    logic [31:0] d; logic [1:0] f;
    wr(12'hB02, 32'hFFFF_FFFE, 2'd2);
    rd(12'hB02, 2'd3, 1'b0, d, f); chk("R3 low write beats increment", d, 32'hFFFF_FFFE);
    rd(12'hB82, 2'd3, 1'b0, d, f); chk("R3 high held on low write", d, 32'h0);
    wr(12'hB82, 32'h0000_00A5, 2'd1);
    rd(12'hC82, 2'd3, 1'b0, d, f); chk("R4 high view after write", d, 32'h0000_00A5);
    rd(12'hC02, 2'd3, 1'b0, d, f); chk("R3 low held on high write", d, 32'hFFFF_FFFE);
    wr(12'h345, 32'h1234_5678, 2'd0);
    rd(12'hC02, 2'd3, 1'b0, d, f); chk("R3 stray write ignored low", d, 32'hFFFF_FFFE);
    rd(12'hC82, 2'd3, 1'b0, d, f); chk("R3 stray write ignored high", d, 32'h0000_00A5);
    @(negedge clk); retire_cnt = 2'd2;
    @(negedge clk); retire_cnt = 2'd0;
    rd(12'hC02, 2'd3, 1'b0, d, f); chk("R2 carry low", d, 32'h0);
    rd(12'hC82, 2'd3, 1'b0, d, f); chk("R2 carry high", d, 32'h0000_00A6);
    wr(12'hB82, 32'hFFFF_FFFF, 2'd0);
    wr(12'hB02, 32'hFFFF_FFFF, 2'd0);
    @(negedge clk); retire_cnt = 2'd2;
    @(negedge clk); retire_cnt = 2'd0;
    rd(12'hC02, 2'd3, 1'b0, d, f); chk("R2 wrap low", d, 32'h1);
    rd(12'hC82, 2'd3, 1'b0, d, f); chk("R2 wrap high", d, 32'h0);
  endtask

  task automatic t_preload;
    wr(12'hB02, 32'h1357_9BDF, 2'd0);
    wr(12'hB82, 32'h2468_ACE0, 2'd0);
  endtask

  // sweeps R5..R10 and R11 data/fault relation
  task automatic t_perm_sweep;
    logic [31:0] d; logic [1:0] f;
    logic [11:0] addrs [6];
    logic [1:0] w; logic [31:0] ed;
    string tag;
    addrs = '{12'hC02, 12'hC82, 12'hB02, 12'hB82, 12'hC00, 12'hC03};
    for (int ai = 0; ai < 6; ai++)
      for (int m = 0; m < 4; m++)
        for (int v = 0; v < 2; v++)
          for (int bits = 0; bits < 16; bits++) begin
            @(negedge clk);
            en_m = bits[0]; en_s = bits[1]; en_h = bits[2]; s_present = bits[3];
            rd(addrs[ai], 2'(m), v[0], d, f);
            w = want(2'(m), v[0], bits[3], bits[0], bits[1], bits[2], addrs[ai]);
            ed = (w != 2'b00) ? 32'h0
               : ((addrs[ai] == 12'hC82 || addrs[ai] == 12'hB82) ? exp_cnt[63:32] : exp_cnt[31:0]);
            if (ai >= 4 || m == 2) tag = "R10";
            else if (ai >= 2 || m == 3) tag = "R5";
            else if (m == 1) tag = v ? "R8" : "R6";
            else tag = v ? "R9" : "R7";
            chk($sformatf("%s faults a=%h m=%0d v=%0d b=%b", tag, addrs[ai], m, v, bits[3:0]),
                {30'h0, f}, {30'h0, w});
            chk($sformatf("R4/R11 data a=%h m=%0d v=%0d b=%b", addrs[ai], m, v, bits[3:0]), d, ed);
          end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_idle();
    t_increment();
    t_write_and_carry();
    t_preload();
    t_perm_sweep();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule